// File: doc/BRIEF.md
# Interrupt Return and Call-Stack Unit

This unit is the return path of a small 8-bit controller core. It owns a hardware stack of return addresses and the working (W), status and bank-select registers, together with one shadow copy of each. It also holds the two global interrupt enables, one for the high priority level and one for the low level. It watches the instruction word presented in the decode cycle and acts on four kinds of word:
- a subroutine call,
- a plain return,
- a return from interrupt,
- a return that loads an 8-bit literal into W.

When it accepts an interrupt request, it pushes the current PC, snapshots W, status and bank-select into the shadows, clears the enable of the level being serviced and steers fetch to that level's vector.

Every accepted call, return or interrupt entry is a redirect. In the following cycle the unit raises `flush` for exactly one cycle and presents the new fetch address on `pc_tgt`. The fetched word is discarded in that cycle, so each return costs two cycles. Instructions and interrupt requests presented while `flush` is high are ignored. The ALU writes W, status and bank-select through write-enable ports. Software writes the enables through a write port. The stack reports overflow and underflow through sticky flags.

The `rst_n` input is asynchronous and active low. Its release is synchronised inside the unit, so the unit leaves reset two clock edges after `rst_n` rises.

Top module: `irq_return_unit`

## Requirements
- R1: A word with bits [15:8] = 8'hEC is a call. It pushes `pc_in` and redirects to `call_tgt`. W, status and bank-select are unchanged.
- R2: A word 0000_1100_kkkk_kkkk pops the stack into `pc_tgt` and loads k into W. The new W is visible in the flush cycle.
- R3: The word 0000_0000_0001_001s is a plain return and pops the stack. With s (bit 0) = 1 it also restores W, status and bank-select from the shadows. It never changes either interrupt enable.
- R4: The word 0000_0000_0001_000s is a return from interrupt and pops the stack. With s = 1 it restores W, status and bank-select from the shadows. With s = 0 it leaves those three registers as they were.
- R5: A return from interrupt sets the high enable if it is clear, and otherwise sets the low enable. Nested low-then-high service therefore re-arms each level in turn.
- R6: After every accepted redirect, `flush` is high for exactly one cycle. Instruction words and interrupt requests presented during that cycle have no effect.
- R7: A high request is taken when `irq_hi` is high and the high enable is set. A low request is taken when `irq_lo` is high, both enables are set and `irq_hi` is low. A taken request has priority over the instruction in decode. Entry pushes `pc_in`, snapshots the three registers, clears the serviced level's enable and redirects to 0x000008 (high) or 0x000018 (low).
- R8: While the relevant enable is clear, an interrupt request causes no redirect.
- R9: The stack holds 31 entries of 21 bits. A push onto a full stack is discarded and sets the sticky `stk_ovf` flag.
- R10: A pop from an empty stack returns address 0 and sets the sticky `stk_unf` flag.
- R11: After reset, `flush`, W, status, bank-select, both enables and both stack flags are 0.
- R12: `gie_we` writes `gie_wd` into the enables, with bit 1 going to high and bit 0 to low. `w_we`, `st_we` and `bsr_we` write their registers when no return is restoring or loading them in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word in decode is valid |
| instr | input | 16 | Instruction word in decode |
| pc_in | input | 21 | Return address to push on a call or interrupt |
| call_tgt | input | 21 | Destination of a call |
| irq_hi | input | 1 | High-priority interrupt request |
| irq_lo | input | 1 | Low-priority interrupt request |
| gie_we | input | 1 | Software write of the enables |
| gie_wd | input | 2 | Enable write data: bit 1 high, bit 0 low |
| w_we | input | 1 | ALU write of W |
| w_wd | input | 8 | ALU data for W |
| st_we | input | 1 | ALU write of status |
| st_wd | input | 5 | ALU data for status (N, OV, Z, DC, C) |
| bsr_we | input | 1 | ALU write of bank-select |
| bsr_wd | input | 4 | ALU data for bank-select |
| flush | output | 1 | Discard the fetched word and fetch from `pc_tgt` |
| pc_tgt | output | 21 | Redirect address, valid while `flush` is high |
| w_q | output | 8 | W register |
| status_q | output | 5 | Status register |
| bsr_q | output | 4 | Bank-select register |
| gie_h | output | 1 | High-priority global enable |
| gie_l | output | 1 | Low-priority global enable |
| stk_ovf | output | 1 | Sticky stack overflow |
| stk_unf | output | 1 | Sticky stack underflow |

## Verification
The assertions check the following on every cycle:
- `flush` never lasts beyond one cycle.
- The stack flags stay set once raised.
- A taken high request always clears its enable and lands on the high vector.
- No redirect happens without a request or instruction while the high enable is clear.
- An accepted literal return writes its literal into W.
- An accepted return from interrupt leaves an enable set.
- A non-fast return from interrupt leaves W alone.

Only the bench's scenarios can show:
- the values popped in the right order across nested calls,
- the shadow contents surviving a nested interrupt,
- the level re-arm order,
- the discarded 32nd push,
- the zero returned on underflow.

// File: rtl/irq_ret_pkg.sv
package irq_ret_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_CALL,
    OP_RET,
    OP_RETFIE,
    OP_RETLW
  } op_e;

  // Instruction classes follow the fixed 16-bit encodings of the core.
  function automatic op_e decode_op(input logic [15:0] iw);
    if (iw[15:8] == 8'hEC)
      return OP_CALL;
    else if (iw[15:8] == 8'h0C)
      return OP_RETLW;
    else if (iw[15:1] == 15'h0009)
      return OP_RET;
    else if (iw[15:1] == 15'h0008)
      return OP_RETFIE;
    else
      return OP_NONE;
  endfunction

endpackage

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int AW    = 21,
  parameter int DEPTH = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] top,
  output logic          ovf,
  output logic          unf
);
  localparam int PW = $clog2(DEPTH + 1);

  logic [PW-1:0] sp_q, sp_d;
  logic          ovf_q, ovf_d, unf_q, unf_d;
  logic          full, empty;
  logic [AW-1:0] mem [DEPTH];

  assign full  = (sp_q == PW'(DEPTH));
  assign empty = (sp_q == '0);

  always_comb begin
    sp_d  = sp_q;
    ovf_d = ovf_q;
    unf_d = unf_q;
    if (push) begin
      if (full) ovf_d = 1'b1;
      else      sp_d  = sp_q + 1'b1;
    end
    if (pop) begin
      if (empty) unf_d = 1'b1;
      else       sp_d  = sp_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      sp_q  <= sp_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  // Storage carries no reset; only the pointer qualifies its contents.
  always_ff @(posedge clk) begin
    if (push && !full) mem[sp_q] <= din;
  end

  assign top = empty ? '0 : mem[PW'(sp_q - 1'b1)];
  assign ovf = ovf_q;
  assign unf = unf_q;
endmodule

// File: rtl/ret_shadow.sv
module ret_shadow #(
  parameter int DW = 8,
  parameter int SW = 5,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snap,
  input  logic          restore,
  input  logic          lit_we,
  input  logic [DW-1:0] lit,
  input  logic          w_we,
  input  logic [DW-1:0] w_wd,
  input  logic          st_we,
  input  logic [SW-1:0] st_wd,
  input  logic          bsr_we,
  input  logic [BW-1:0] bsr_wd,
  output logic [DW-1:0] w_q,
  output logic [SW-1:0] st_q,
  output logic [BW-1:0] bsr_q
);
  logic [DW-1:0] w_d, ws_q, ws_d;
  logic [SW-1:0] st_d, sts_q, sts_d;
  logic [BW-1:0] bsr_d, bs_q, bs_d;

  always_comb begin
    w_d   = w_q;
    st_d  = st_q;
    bsr_d = bsr_q;
    if (w_we)   w_d   = w_wd;
    if (st_we)  st_d  = st_wd;
    if (bsr_we) bsr_d = bsr_wd;
    if (lit_we) w_d   = lit;
    if (restore) begin
      w_d   = ws_q;
      st_d  = sts_q;
      bsr_d = bs_q;
    end
    ws_d  = snap ? w_q   : ws_q;
    sts_d = snap ? st_q  : sts_q;
    bs_d  = snap ? bsr_q : bs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q   <= '0;
      st_q  <= '0;
      bsr_q <= '0;
      ws_q  <= '0;
      sts_q <= '0;
      bs_q  <= '0;
    end else begin
      w_q   <= w_d;
      st_q  <= st_d;
      bsr_q <= bsr_d;
      ws_q  <= ws_d;
      sts_q <= sts_d;
      bs_q  <= bs_d;
    end
  end
endmodule

// File: rtl/ret_gie.sv
module ret_gie (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_hi,
  input  logic       clr_lo,
  input  logic       rearm,
  input  logic       sw_we,
  input  logic [1:0] sw_wd,
  output logic       gie_h,
  output logic       gie_l
);
  logic h_d, l_d;

  always_comb begin
    h_d = gie_h;
    l_d = gie_l;
    if (sw_we) begin
      h_d = sw_wd[1];
      l_d = sw_wd[0];
    end
    if (clr_hi) h_d = 1'b0;
    if (clr_lo) l_d = 1'b0;
    if (rearm) begin
      if (!gie_h) h_d = 1'b1;
      else        l_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_h <= 1'b0;
      gie_l <= 1'b0;
    end else begin
      gie_h <= h_d;
      gie_l <= l_d;
    end
  end
endmodule

// File: rtl/irq_return_unit.sv
module irq_return_unit
  import irq_ret_pkg::*;
#(
  parameter int PC_W      = 21,
  parameter int STK_DEPTH = 31,
  parameter int W_W       = 8,
  parameter int ST_W      = 5,
  parameter int BSR_W     = 4,
  parameter int HI_VEC    = 8,
  parameter int LO_VEC    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  input  logic [15:0]      instr,
  input  logic [PC_W-1:0]  pc_in,
  input  logic [PC_W-1:0]  call_tgt,
  input  logic             irq_hi,
  input  logic             irq_lo,
  input  logic             gie_we,
  input  logic [1:0]       gie_wd,
  input  logic             w_we,
  input  logic [W_W-1:0]   w_wd,
  input  logic             st_we,
  input  logic [ST_W-1:0]  st_wd,
  input  logic             bsr_we,
  input  logic [BSR_W-1:0] bsr_wd,
  output logic             flush,
  output logic [PC_W-1:0]  pc_tgt,
  output logic [W_W-1:0]   w_q,
  output logic [ST_W-1:0]  status_q,
  output logic [BSR_W-1:0] bsr_q,
  output logic             gie_h,
  output logic             gie_l,
  output logic             stk_ovf,
  output logic             stk_unf
);
  logic [1:0]      rst_pipe;
  logic            rst_s_n;
  logic            take_hi, take_lo, take;
  op_e             op;
  logic            push, pop, redirect, fast;
  logic [PC_W-1:0] stk_top, tgt_d, pc_tgt_q;
  logic            flush_q;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  always_comb begin
    take_hi  = irq_hi && gie_h && !flush_q;
    take_lo  = irq_lo && gie_h && gie_l && !irq_hi && !flush_q;
    take     = take_hi || take_lo;
    op       = (instr_valid && !flush_q && !take) ? decode_op(instr) : OP_NONE;
    push     = take || (op == OP_CALL);
    pop      = (op == OP_RET) || (op == OP_RETFIE) || (op == OP_RETLW);
    redirect = push || pop;
    fast     = ((op == OP_RET) || (op == OP_RETFIE)) && instr[0];
    tgt_d    = pc_tgt_q;
    if (take_hi)              tgt_d = PC_W'(HI_VEC);
    else if (take_lo)         tgt_d = PC_W'(LO_VEC);
    else if (op == OP_CALL)   tgt_d = call_tgt;
    else if (pop)             tgt_d = stk_top;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      flush_q  <= 1'b0;
      pc_tgt_q <= '0;
    end else begin
      flush_q <= redirect;
      if (redirect) pc_tgt_q <= tgt_d;
    end
  end

  ret_stack #(.AW(PC_W), .DEPTH(STK_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_s_n), .push(push), .pop(pop), .din(pc_in),
    .top(stk_top), .ovf(stk_ovf), .unf(stk_unf)
  );

  ret_shadow #(.DW(W_W), .SW(ST_W), .BW(BSR_W)) u_shadow (
    .clk(clk), .rst_n(rst_s_n), .snap(take), .restore(fast),
    .lit_we(op == OP_RETLW), .lit(instr[7:0]),
    .w_we(w_we), .w_wd(w_wd), .st_we(st_we), .st_wd(st_wd),
    .bsr_we(bsr_we), .bsr_wd(bsr_wd),
    .w_q(w_q), .st_q(status_q), .bsr_q(bsr_q)
  );

  ret_gie u_gie (
    .clk(clk), .rst_n(rst_s_n), .clr_hi(take_hi), .clr_lo(take_lo),
    .rearm(op == OP_RETFIE), .sw_we(gie_we), .sw_wd(gie_wd),
    .gie_h(gie_h), .gie_l(gie_l)
  );

  assign flush  = flush_q;
  assign pc_tgt = pc_tgt_q;
endmodule

// File: rtl/irq_return_unit_chk.sv
module irq_return_unit_chk #(
  parameter int PC_W   = 21,
  parameter int W_W    = 8,
  parameter int HI_VEC = 8
) (
  input logic            clk,
  input logic            rst_s_n,
  input logic            instr_valid,
  input logic [15:0]     instr,
  input logic            irq_hi,
  input logic            irq_lo,
  input logic            w_we,
  input logic            flush,
  input logic [PC_W-1:0] pc_tgt,
  input logic [W_W-1:0]  w_q,
  input logic            gie_h,
  input logic            gie_l,
  input logic            stk_ovf,
  input logic            stk_unf
);
  logic acc;
  assign acc = instr_valid && !flush && !irq_hi && !irq_lo;

  p_flush_single_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    flush |=> !flush);

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    stk_ovf |=> stk_ovf);

  p_unf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    stk_unf |=> stk_unf);

  p_literal_w_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (acc && instr[15:8] == 8'h0C) |=> (flush && w_q == W_W'($past(instr[7:0]))));

  p_rearm_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (acc && instr[15:1] == 15'h0008) |=> (flush && (gie_h || gie_l)));

  p_keep_w_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (acc && instr == 16'h0010 && !w_we) |=> (w_q == $past(w_q)));

  p_hi_entry_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (irq_hi && gie_h && !flush) |=> (flush && !gie_h && pc_tgt == PC_W'(HI_VEC)));

  p_blocked_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!instr_valid && !gie_h) |=> !flush);
endmodule

bind irq_return_unit irq_return_unit_chk #(
  .PC_W(PC_W), .W_W(W_W), .HI_VEC(HI_VEC)
) u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .instr_valid(instr_valid), .instr(instr),
  .irq_hi(irq_hi), .irq_lo(irq_lo), .w_we(w_we), .flush(flush),
  .pc_tgt(pc_tgt), .w_q(w_q), .gie_h(gie_h), .gie_l(gie_l),
  .stk_ovf(stk_ovf), .stk_unf(stk_unf)
);

// File: tb/irq_return_unit_test.sv
module irq_return_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [15:0] instr;
  logic [20:0] pc_in, call_tgt;
  logic        irq_hi, irq_lo, gie_we;
  logic [1:0]  gie_wd;
  logic        w_we, st_we, bsr_we;
  logic [7:0]  w_wd;
  logic [4:0]  st_wd;
  logic [3:0]  bsr_wd;
  logic        flush, gie_h, gie_l, stk_ovf, stk_unf;
  logic [20:0] pc_tgt;
  logic [7:0]  w_q;
  logic [4:0]  status_q;
  logic [3:0]  bsr_q;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  irq_return_unit uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .pc_in(pc_in), .call_tgt(call_tgt), .irq_hi(irq_hi), .irq_lo(irq_lo),
    .gie_we(gie_we), .gie_wd(gie_wd), .w_we(w_we), .w_wd(w_wd),
    .st_we(st_we), .st_wd(st_wd), .bsr_we(bsr_we), .bsr_wd(bsr_wd),
    .flush(flush), .pc_tgt(pc_tgt), .w_q(w_q), .status_q(status_q),
    .bsr_q(bsr_q), .gie_h(gie_h), .gie_l(gie_l),
    .stk_ovf(stk_ovf), .stk_unf(stk_unf)
  );

  // Each entry: instruction, pc_in, call_tgt, expected pc_tgt, expected W.
  localparam int VW = 16 + 21 + 21 + 21 + 8;
  localparam logic [VW-1:0] VEC [6] = '{
    {16'hEC00, 21'h000100, 21'h002000, 21'h002000, 8'h00},
    {16'hEC00, 21'h002004, 21'h003000, 21'h003000, 8'h00},
    {16'h0C5A, 21'h000000, 21'h000000, 21'h002004, 8'h5A},
    {16'hEC00, 21'h1FFFFE, 21'h000040, 21'h000040, 8'h5A},
    {16'h0CFF, 21'h000000, 21'h000000, 21'h1FFFFE, 8'hFF},
    {16'h0C00, 21'h000000, 21'h000000, 21'h000100, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Present a word for one decode cycle; returns in the flush cycle.
  task automatic issue(input logic [15:0] iw, input logic [20:0] pc, input logic [20:0] tgt);
    instr_valid = 1'b1; instr = iw; pc_in = pc; call_tgt = tgt;
    @(negedge clk);
    instr_valid = 1'b0; instr = 16'h0000;
  endtask

  task automatic raise(input logic hi, input logic [20:0] pc);
    irq_hi = hi; irq_lo = !hi; pc_in = pc;
    @(negedge clk);
    irq_hi = 1'b0; irq_lo = 1'b0;
  endtask

  task automatic regwr(input logic [7:0] w, input logic [4:0] s, input logic [3:0] b);
    w_we = 1'b1; st_we = 1'b1; bsr_we = 1'b1; w_wd = w; st_wd = s; bsr_wd = b;
    @(negedge clk);
    w_we = 1'b0; st_we = 1'b0; bsr_we = 1'b0;
  endtask

  task automatic giewr(input logic [1:0] v);
    gie_we = 1'b1; gie_wd = v;
    @(negedge clk);
    gie_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; instr_valid = 1'b0; instr = '0; pc_in = '0; call_tgt = '0;
    irq_hi = 1'b0; irq_lo = 1'b0; gie_we = 1'b0; gie_wd = '0;
    w_we = 1'b0; st_we = 1'b0; bsr_we = 1'b0; w_wd = '0; st_wd = '0; bsr_wd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    chk("R11 flush", flush, 0);
    chk("R11 w", w_q, 0);
    chk("R11 status", status_q, 0);
    chk("R11 bsr", bsr_q, 0);
    chk("R11 gie", {gie_h, gie_l}, 0);
    chk("R11 flags", {stk_ovf, stk_unf}, 0);

    // R1 R2 R6 vector table: nested calls and literal returns
    for (int i = 0; i < 6; i++) begin
      issue(VEC[i][86:71], VEC[i][70:50], VEC[i][49:29]);
      chk("R6 flush in second cycle", flush, 1);
      chk(VEC[i][86:79] == 8'hEC ? "R1 call target" : "R2 popped pc", pc_tgt, VEC[i][28:8]);
      chk(VEC[i][86:79] == 8'hEC ? "R1 W unchanged" : "R2 literal W", w_q, VEC[i][7:0]);
      @(negedge clk);
      chk("R6 flush one cycle", flush, 0);
    end

    // R8 requests blocked while enables are clear
    raise(1'b1, 21'h000500);
    chk("R8 hi blocked", flush, 0);
    raise(1'b0, 21'h000500);
    chk("R8 lo blocked", flush, 0);

    // R12 software and ALU writes
    giewr(2'b11);
    chk("R12 gie write", {gie_h, gie_l}, 2'b11);
    regwr(8'h33, 5'h15, 4'hA);
    chk("R12 alu write", {w_q, 3'b0, status_q, 4'b0, bsr_q}, {8'h33, 3'b0, 5'h15, 4'b0, 4'hA});

    // R7 high entry then fast return from interrupt (R4 R5)
    raise(1'b1, 21'h000500);
    chk("R7 hi vector", pc_tgt, 21'h000008);
    chk("R7 hi flush", flush, 1);
    chk("R7 hi enable cleared", {gie_h, gie_l}, 2'b01);
    @(negedge clk);
    regwr(8'h77, 5'h02, 4'h3);
    issue(16'h0011, 21'h0, 21'h0);
    chk("R4 fast pc", pc_tgt, 21'h000500);
    chk("R4 fast W", w_q, 8'h33);
    chk("R4 fast status", status_q, 5'h15);
    chk("R4 fast bsr", bsr_q, 4'hA);
    chk("R5 hi rearm", {gie_h, gie_l}, 2'b11);
    @(negedge clk);

    // R7 low entry, nested high, two plain returns from interrupt
    raise(1'b0, 21'h000600);
    chk("R7 lo vector", pc_tgt, 21'h000018);
    chk("R7 lo enable cleared", {gie_h, gie_l}, 2'b10);
    @(negedge clk);
    w_we = 1'b1; w_wd = 8'h44; @(negedge clk); w_we = 1'b0;
    raise(1'b1, 21'h000020);
    chk("R7 nested hi vector", pc_tgt, 21'h000008);
    chk("R7 nested enables", {gie_h, gie_l}, 2'b00);
    @(negedge clk);
    issue(16'h0010, 21'h0, 21'h0);
    chk("R4 nested pc", pc_tgt, 21'h000020);
    chk("R4 no restore W", w_q, 8'h44);
    chk("R5 high first", {gie_h, gie_l}, 2'b10);
    @(negedge clk);
    issue(16'h0010, 21'h0, 21'h0);
    chk("R4 outer pc", pc_tgt, 21'h000600);
    chk("R5 low second", {gie_h, gie_l}, 2'b11);
    @(negedge clk);

    // R6 word and request during flush cycle are ignored
    issue(16'hEC00, 21'h000700, 21'h000900);
    chk("R1 call target", pc_tgt, 21'h000900);
    instr_valid = 1'b1; instr = 16'h0C99; irq_hi = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0; instr = '0; irq_hi = 1'b0;
    chk("R6 no redirect", flush, 0);
    chk("R6 W untouched", w_q, 8'h44);
    chk("R6 enables untouched", {gie_h, gie_l}, 2'b11);
    issue(16'h0012, 21'h0, 21'h0);
    chk("R3 plain return pc", pc_tgt, 21'h000700);
    @(negedge clk);

    // R3 fast plain return restores but keeps enables
    raise(1'b1, 21'h000800);
    @(negedge clk);
    regwr(8'h01, 5'h00, 4'h0);
    issue(16'h0013, 21'h0, 21'h0);
    chk("R3 fast pc", pc_tgt, 21'h000800);
    chk("R3 fast W", w_q, 8'h44);
    chk("R3 fast bsr", bsr_q, 4'hA);
    chk("R3 enables kept", {gie_h, gie_l}, 2'b01);
    @(negedge clk);

    // R10 underflow
    chk("R10 no underflow yet", stk_unf, 0);
    issue(16'h0012, 21'h0, 21'h0);
    chk("R10 empty pop returns zero", pc_tgt, 0);
    chk("R10 underflow set", stk_unf, 1);
    repeat (3) @(negedge clk);
    chk("R10 underflow sticky", stk_unf, 1);

    // R9 overflow
    for (int k = 1; k <= 31; k++) begin
      issue(16'hEC00, 21'(k), 21'h000040);
      @(negedge clk);
    end
    chk("R9 full no overflow", stk_ovf, 0);
    issue(16'hEC00, 21'd32, 21'h000040);
    chk("R9 overflow set", stk_ovf, 1);
    @(negedge clk);
    issue(16'h0012, 21'h0, 21'h0);
    chk("R9 extra push dropped", pc_tgt, 21'd31);
    @(negedge clk);
    chk("R9 overflow sticky", stk_ovf, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule